// File: doc/BRIEF.md
# Interrupt Mask and Priority Controller

This block gathers level-sensitive interrupt lines from the system's peripherals. It holds a mask for every source and combines the unmasked sources with software-raised levels. From these it drives one processor priority level from 1 to 15, together with a request flag. Software reaches the block through two register banks on a 32-bit word-addressed bus. The processor bank shows the pending levels and raises or drops software levels. The system bank shows the raw sources and holds the source mask. It also stores the number of the processor that takes undirected interrupts.

The mask changes through two write-only ports that act on 1 bits only. This lets separate software agents enable or disable their own sources without a read-modify-write cycle. Mask bit 31 overrides every other bit and silences the request output.

Top module: `imc_top`

## Requirements
- R1: After reset the software levels are clear, the mask reads 0xFFFFFFFF, the target register reads 0, irq_level_o is 0 and irq_req_o is low.
- R2: Address bit 3 selects the bank: 0 is the processor bank and 1 is the system bank. Bits 2:0 select the word. Processor word 0 returns the pending word and ignores writes. Processor word 1 is the soft-clear port and word 2 is the soft-set port.
- R3: The system bank word map is: 0 returns the sampled sources and ignores writes, 1 is the mask (read and write), 2 is the mask-clear port, 3 is the mask-set port, and 4 is the target register (read and write).
- R4: A write to the mask-clear port zeroes the mask bits written as 1, which enables those sources. A write to the mask-set port sets the mask bits written as 1, which disables them. Bits written as 0 leave the mask unchanged.
- R5: Writing 1 to bit 16+x of the soft-set port (x from 1 to 15) makes software level x pending. The level stays pending until bit 16+x is written as 1 to the soft-clear port. Bits 16:0 of both ports have no effect.
- R6: Reads of the clear and set ports, and of unmapped words (processor words 3 to 7, system words 5 to 7), return 0. Writes to unmapped words change no state.
- R7: Each source bit has a fixed level. Bits 6:0 (secondary bus x) give level x+1. Bits 13:7 (slot x at bit x+7) give level x+1. Bit 15 serial gives 12, bit 16 ethernet 6, bit 17 audio 13, bit 18 SCSI 4, bit 19 timer 10, bit 20 video 8, bit 21 module 14, bit 22 floppy 11, and bits 28 to 30 (ECC, write-buffer, module error) give 15. Bits 14, 23 to 27 and 31 raise no level.
- R8: In the processor pending word, bit x is 1 when any active source maps to level x, whatever its mask bit. Bit 16+x is 1 when software level x is pending.
- R9: irq_level_o is the highest level that is either software-pending or driven by an active unmasked source. irq_req_o is high exactly when that level is not 0. Both outputs are registered: a change on src_i shows two clocks later, and a change to the mask or the soft levels shows one clock later.
- R10: While mask bit 31 is set, irq_level_o is 0 and irq_req_o is low, for hardware and software levels alike.
- R11: Read data appears on bus_rdata_o one clock after the read cycle and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 32 | Level interrupt lines, one per source bit |
| bus_valid_i | input | 1 | Bus access this cycle |
| bus_we_i | input | 1 | 1 for a write, 0 for a read |
| bus_addr_i | input | 4 | Bank select (bit 3) and word index (bits 2:0) |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| irq_level_o | output | 4 | Processor priority level requested |
| irq_req_o | output | 1 | Interrupt request to the processor |

## Verification
Some properties are checked on every cycle. Mask-all must silence the request on the next cycle. The request flag must agree with a nonzero level. Set and clear writes may touch only the bits written as 1. Software levels may drop only after a clear write. Port reads must return zero, and the target register must capture what was written. Other behaviour can only be shown by the bench's scenarios. This covers the source-to-level map, the choice of the highest level when several sources are active, and the masked sources still showing as pending. It also covers the two-clock latency from src_i and the writes that must be ignored.

// File: rtl/imc_pkg.sv
package imc_pkg;
  localparam int DATA_W  = 32;
  localparam int NUM_LVL = 16;
  localparam int LVL_W   = $clog2(NUM_LVL);
  localparam int MASK_ALL_BIT = 31;
  localparam int SOFT_LSB = 16;

  // word indices
  localparam logic [2:0] W_CPU_PEND = 3'd0;
  localparam logic [2:0] W_CPU_CLR  = 3'd1;
  localparam logic [2:0] W_CPU_SET  = 3'd2;
  localparam logic [2:0] W_SYS_PEND = 3'd0;
  localparam logic [2:0] W_SYS_MASK = 3'd1;
  localparam logic [2:0] W_SYS_CLR  = 3'd2;
  localparam logic [2:0] W_SYS_SET  = 3'd3;
  localparam logic [2:0] W_SYS_TGT  = 3'd4;

  // fixed fold of source bits onto processor levels; 0 = no level
  function automatic logic [LVL_W-1:0] src_to_lvl(input int b);
    logic [LVL_W-1:0] l;
    l = '0;
    if (b <= 6)                   l = LVL_W'(b + 1);
    else if (b >= 7 && b <= 13)   l = LVL_W'(b - 6);
    else begin
      case (b)
        15: l = LVL_W'(12);
        16: l = LVL_W'(6);
        17: l = LVL_W'(13);
        18: l = LVL_W'(4);
        19: l = LVL_W'(10);
        20: l = LVL_W'(8);
        21: l = LVL_W'(14);
        22: l = LVL_W'(11);
        28, 29, 30: l = LVL_W'(15);
        default: l = '0;
      endcase
    end
    return l;
  endfunction
endpackage

// File: rtl/imc_src_map.sv
module imc_src_map
  import imc_pkg::*;
#(
  parameter int SRC_W = DATA_W,
  parameter int N_LVL = NUM_LVL
) (
  input  logic [SRC_W-1:0] src_i,
  input  logic [SRC_W-1:0] mask_i,
  output logic [N_LVL-1:0] lvl_raw_o,
  output logic [N_LVL-1:0] lvl_en_o
);
  localparam int LW = $clog2(N_LVL);

  for (genvar l = 1; l < N_LVL; l++) begin : g_lvl
    logic raw, en;
    always_comb begin
      raw = 1'b0;
      en  = 1'b0;
      for (int b = 0; b < SRC_W; b++) begin
        if (int'(src_to_lvl(b)) == l && src_i[b]) begin
          raw = 1'b1;
          if (!mask_i[b]) en = 1'b1;
        end
      end
    end
    assign lvl_raw_o[l] = raw;
    assign lvl_en_o[l]  = en;
  end
  assign lvl_raw_o[0] = 1'b0;
  assign lvl_en_o[0]  = 1'b0;

  logic unused_lw;
  assign unused_lw = (LW == 0);
endmodule

// File: rtl/imc_prio_enc.sv
module imc_prio_enc #(
  parameter int N = 16,
  localparam int W = $clog2(N)
) (
  input  logic [N-1:0] req_i,
  output logic [W-1:0] idx_o,
  output logic         any_o
);
  always_comb begin
    idx_o = '0;
    any_o = 1'b0;
    for (int i = 1; i < N; i++) begin
      if (req_i[i]) begin
        idx_o = W'(i);
        any_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/imc_regs.sv
module imc_regs
  import imc_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int N_LVL  = NUM_LVL
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] src_i,
  input  logic              bus_valid_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  input  logic [N_LVL-1:0]  lvl_raw_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic [DATA_W-1:0] src_q_o,
  output logic [DATA_W-1:0] mask_q_o,
  output logic [DATA_W-1:0] target_q_o,
  output logic [N_LVL-1:0]  soft_q_o
);
  localparam int WRD_W = ADDR_W - 1;

  logic              sys_bank;
  logic [WRD_W-1:0]  word;
  logic              wr, rd;
  logic [DATA_W-1:0] src_q, mask_q, target_q, rdata_d, rdata_q;
  logic [N_LVL-1:0]  soft_q, soft_wr;

  assign sys_bank = bus_addr_i[ADDR_W-1];
  assign word     = bus_addr_i[WRD_W-1:0];
  assign wr       = bus_valid_i &  bus_we_i;
  assign rd       = bus_valid_i & ~bus_we_i;
  assign soft_wr  = bus_wdata_i[SOFT_LSB +: N_LVL] & ~N_LVL'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) src_q <= '0;
    else         src_q <= src_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q   <= '1;
      target_q <= '0;
    end else if (wr && sys_bank) begin
      case (word)
        WRD_W'(W_SYS_MASK): mask_q   <= bus_wdata_i;
        WRD_W'(W_SYS_CLR):  mask_q   <= mask_q & ~bus_wdata_i;
        WRD_W'(W_SYS_SET):  mask_q   <= mask_q |  bus_wdata_i;
        WRD_W'(W_SYS_TGT):  target_q <= bus_wdata_i;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) soft_q <= '0;
    else if (wr && !sys_bank) begin
      case (word)
        WRD_W'(W_CPU_CLR): soft_q <= soft_q & ~soft_wr;
        WRD_W'(W_CPU_SET): soft_q <= soft_q |  soft_wr;
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_d = '0;
    if (sys_bank) begin
      case (word)
        WRD_W'(W_SYS_PEND): rdata_d = src_q;
        WRD_W'(W_SYS_MASK): rdata_d = mask_q;
        WRD_W'(W_SYS_TGT):  rdata_d = target_q;
        default:            rdata_d = '0;
      endcase
    end else if (word == WRD_W'(W_CPU_PEND)) begin
      rdata_d[SOFT_LSB +: N_LVL] = soft_q;
      rdata_d[N_LVL-1:0]         = lvl_raw_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_q <= '0;
    else if (rd)  rdata_q <= rdata_d;
  end

  assign bus_rdata_o = rdata_q;
  assign src_q_o     = src_q;
  assign mask_q_o    = mask_q;
  assign target_q_o  = target_q;
  assign soft_q_o    = soft_q;
endmodule

// File: rtl/imc_top.sv
module imc_top
  import imc_pkg::*;
#(
  parameter int ADDR_W = 4,
  localparam int LW = LVL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] src_i,
  input  logic              bus_valid_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic [LW-1:0]     irq_level_o,
  output logic              irq_req_o
);
  logic [DATA_W-1:0]  src_w, mask_w, target_w;
  logic [NUM_LVL-1:0] soft_w, lvl_raw, lvl_en, lvl_req;
  logic [LW-1:0]      lvl_d, lvl_q;
  logic               any_d, req_q;

  imc_regs #(.ADDR_W(ADDR_W), .N_LVL(NUM_LVL)) u_regs (
    .clk_i, .rst_ni, .src_i,
    .bus_valid_i, .bus_we_i, .bus_addr_i, .bus_wdata_i,
    .lvl_raw_i  (lvl_raw),
    .bus_rdata_o,
    .src_q_o    (src_w),
    .mask_q_o   (mask_w),
    .target_q_o (target_w),
    .soft_q_o   (soft_w)
  );

  imc_src_map #(.SRC_W(DATA_W), .N_LVL(NUM_LVL)) u_map (
    .src_i     (src_w),
    .mask_i    (mask_w),
    .lvl_raw_o (lvl_raw),
    .lvl_en_o  (lvl_en)
  );

  assign lvl_req = (lvl_en | soft_w) & {NUM_LVL{~mask_w[MASK_ALL_BIT]}};

  imc_prio_enc #(.N(NUM_LVL)) u_prio (
    .req_i (lvl_req),
    .idx_o (lvl_d),
    .any_o (any_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= '0;
      req_q <= 1'b0;
    end else begin
      lvl_q <= lvl_d;
      req_q <= any_d;
    end
  end

  assign irq_level_o = lvl_q;
  assign irq_req_o   = req_q;

  logic unused_tgt;
  assign unused_tgt = ^target_w;
endmodule

// File: rtl/imc_checker.sv
module imc_checker
  import imc_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_valid_i,
  input logic              bus_we_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [DATA_W-1:0] bus_wdata_i,
  input logic [DATA_W-1:0] bus_rdata_o,
  input logic [LVL_W-1:0]  irq_level_o,
  input logic              irq_req_o,
  input logic [DATA_W-1:0] mask_q,
  input logic [DATA_W-1:0] target_q,
  input logic [NUM_LVL-1:0] soft_q
);
  localparam int WRD_W = ADDR_W - 1;
  logic sys, wr, rd, zero_rd, set_wr, clr_wr, tgt_wr, soft_clr_wr;
  logic [WRD_W-1:0] wd;
  assign sys = bus_addr_i[ADDR_W-1];
  assign wd  = bus_addr_i[WRD_W-1:0];
  assign wr  = bus_valid_i &  bus_we_i;
  assign rd  = bus_valid_i & ~bus_we_i;
  assign set_wr = wr & sys & (wd == WRD_W'(W_SYS_SET));
  assign clr_wr = wr & sys & (wd == WRD_W'(W_SYS_CLR));
  assign tgt_wr = wr & sys & (wd == WRD_W'(W_SYS_TGT));
  assign soft_clr_wr = wr & ~sys & (wd == WRD_W'(W_CPU_CLR));
  assign zero_rd = rd & (sys ? (wd == WRD_W'(W_SYS_CLR) || wd == WRD_W'(W_SYS_SET) || wd > WRD_W'(W_SYS_TGT))
                             : (wd != WRD_W'(W_CPU_PEND)));

  a_r10_mask_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_q[MASK_ALL_BIT] |=> !irq_req_o);
  a_r9_req_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_req_o |-> irq_level_o != '0);
  a_r9_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_req_o |-> irq_level_o == '0);
  a_r4_set_ones: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_wr |=> ((mask_q & $past(bus_wdata_i)) == $past(bus_wdata_i)) &&
               ((mask_q & ~$past(bus_wdata_i)) == ($past(mask_q) & ~$past(bus_wdata_i))));
  a_r4_clr_ones: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_wr |=> ((mask_q & $past(bus_wdata_i)) == '0) &&
               ((mask_q & ~$past(bus_wdata_i)) == ($past(mask_q) & ~$past(bus_wdata_i))));
  a_r6_port_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_rd |=> bus_rdata_o == '0);
  a_r3_target_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tgt_wr |=> target_q == $past(bus_wdata_i));
  a_r5_soft_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !soft_clr_wr |=> (soft_q & $past(soft_q)) == $past(soft_q));
endmodule

bind imc_top imc_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_valid_i (bus_valid_i),
  .bus_we_i    (bus_we_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .bus_rdata_o (bus_rdata_o),
  .irq_level_o (irq_level_o),
  .irq_req_o   (irq_req_o),
  .mask_q      (mask_w),
  .target_q    (target_w),
  .soft_q      (soft_w)
);

// File: tb/imc_top_tb.sv
module imc_top_tb;
  localparam int CLK_NS = 4;
  localparam int NV = 10;
  // {src, mask, expected level}
  localparam logic [67:0] VEC [NV] = '{
    {32'h0001_0000, 32'h0000_0000, 4'd6},
    {32'h0009_0000, 32'h0000_0000, 4'd10},
    {32'h0009_0000, 32'h0008_0000, 4'd6},
    {32'h1000_0080, 32'h0000_0000, 4'd15},
    {32'h0000_2000, 32'h0000_0000, 4'd7},
    {32'h0000_0001, 32'h0000_0000, 4'd1},
    {32'h0000_4000, 32'h0000_0000, 4'd0},
    {32'hFFFF_FFFF, 32'h8000_0000, 4'd0},
    {32'h0004_0000, 32'h7FFB_FFFF, 4'd4},
    {32'h0010_8000, 32'h0000_0000, 4'd12}
  };

  logic        clk = 0, rst_ni = 0;
  logic [31:0] src_i = '0, wdata = '0;
  logic        valid = 0, we = 0;
  logic [3:0]  addr = '0;
  logic [31:0] rdata;
  logic [3:0]  level;
  logic        req;
  int checks = 0, fails = 0;
  logic [31:0] r;

  always #(CLK_NS/2) clk = ~clk;

  imc_top u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .src_i(src_i),
    .bus_valid_i(valid), .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .irq_level_o(level), .irq_req_o(req)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); valid = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); valid = 0; we = 0; wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); valid = 1; we = 0; addr = a;
    @(negedge clk); d = rdata; valid = 0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic chk_out(input string tag, input logic [3:0] exp);
    chk(tag, {28'd0, level}, {28'd0, exp});
    chk(tag, {31'd0, req}, {31'd0, exp != 0});
  endtask

  initial begin
    #(CLK_NS * 200000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    // R1 reset state
    chk_out("R1 outputs", 4'd0);
    rd(4'h9, r); chk("R1 mask", r, 32'hFFFF_FFFF);
    rd(4'hC, r); chk("R1 target", r, 32'h0);
    rd(4'h0, r); chk("R1 cpu pend", r, 32'h0);

    // R7 R9 vector table
    for (int i = 0; i < NV; i++) begin
      wr(4'h9, VEC[i][35:4]);
      @(negedge clk); src_i = VEC[i][67:36];
      settle();
      chk($sformatf("R7 R9 vec%0d", i), {28'd0, level}, {28'd0, VEC[i][3:0]});
      chk($sformatf("R9 req vec%0d", i), {31'd0, req}, {31'd0, VEC[i][3:0] != 0});
    end

    // R9 latency from src_i: two clocks
    wr(4'h9, 32'h0); src_i = '0; settle();
    @(negedge clk); src_i = 32'h0008_0000;
    @(negedge clk); chk("R9 lat1", {28'd0, level}, 32'd0);
    @(negedge clk); chk("R9 lat2", {28'd0, level}, 32'd10);

    // R3 system pending reads sampled sources; writes ignored
    wr(4'h8, 32'h0);
    rd(4'h8, r); chk("R3 sys pend", r, 32'h0008_0000);

    // R8 masked source still pending in cpu word, no request
    src_i = 32'h0001_0000; wr(4'h9, 32'hFFFF_FFFF); settle();
    rd(4'h0, r); chk("R8 hw pend", r, 32'h0000_0040);
    chk_out("R8 masked", 4'd0);

    // R4 set/clear ports act on ones only
    wr(4'h9, 32'h0);
    wr(4'hB, 32'h0001_0000); rd(4'h9, r); chk("R4 set", r, 32'h0001_0000);
    wr(4'hA, 32'h0);         rd(4'h9, r); chk("R4 clr zero", r, 32'h0001_0000);
    wr(4'hB, 32'h0);         rd(4'h9, r); chk("R4 set zero", r, 32'h0001_0000);
    wr(4'hA, 32'h0001_0000); rd(4'h9, r); chk("R4 clr", r, 32'h0);
    settle(); chk_out("R4 enabled", 4'd6);

    // R5 soft levels: set, hold, clear; low bits ignored
    src_i = '0;
    wr(4'h2, 32'h0001_FFFF); rd(4'h0, r); chk("R5 low ignored", r, 32'h0);
    wr(4'h2, 32'h0008_0000);
    @(negedge clk); chk_out("R9 soft lat", 4'd3);
    repeat (5) @(negedge clk); chk_out("R5 hold", 4'd3);
    rd(4'h0, r); chk("R8 soft pend", r, 32'h0008_0000);
    wr(4'h1, 32'h0000_FFFF); rd(4'h0, r); chk("R5 clr low ignored", r, 32'h0008_0000);
    // R10 mask-all silences soft
    wr(4'hB, 32'h8000_0000); settle(); chk_out("R10 soft", 4'd0);
    wr(4'hA, 32'h8000_0000); settle(); chk_out("R10 release", 4'd3);
    wr(4'h1, 32'h0008_0000); settle(); chk_out("R5 cleared", 4'd0);

    // R9 soft and hw compete
    src_i = 32'h0008_0000; wr(4'h2, 32'h0010_0000); settle();
    chk_out("R9 soft vs hw", 4'd10);
    wr(4'h2, 32'h8000_0000); settle();
    chk_out("R9 soft top", 4'd15);
    wr(4'h1, 32'hFFFF_0000); src_i = '0;

    // R3 target register
    wr(4'hC, 32'h0000_0003); rd(4'hC, r); chk("R3 target", r, 32'h3);
    // R6 port and unmapped reads, unmapped writes
    rd(4'h1, r); chk("R6 cpu clr rd", r, 32'h0);
    rd(4'h2, r); chk("R6 cpu set rd", r, 32'h0);
    rd(4'hA, r); chk("R6 sys clr rd", r, 32'h0);
    rd(4'hB, r); chk("R6 sys set rd", r, 32'h0);
    rd(4'h3, r); chk("R6 cpu unmapped", r, 32'h0);
    wr(4'hD, 32'hFFFF_FFFF); wr(4'h5, 32'hFFFF_FFFF);
    rd(4'hD, r); chk("R6 sys unmapped", r, 32'h0);
    rd(4'hC, r); chk("R6 target kept", r, 32'h3);
    rd(4'h9, r); chk("R6 mask kept", r, 32'h0);
    rd(4'h0, r); chk("R6 soft kept", r, 32'h0);
    // R2 cpu word 0 ignores writes
    wr(4'h0, 32'hFFFF_FFFF); rd(4'h0, r); chk("R2 pend ro", r, 32'h0);
    // R11 read data holds
    rd(4'hC, r); repeat (3) @(negedge clk); chk("R11 hold", rdata, 32'h3);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule